// File: doc/BRIEF.md
# DRAM Geometry Alias Probe Memory

This block stands in for a DRAM device during boot-time size detection. Firmware probing for the memory size programs a row, bank and column width, writes marker words at chosen offsets and reads them back at others. A real part that is smaller than the programmed geometry repeats its contents at several offsets. This block reproduces that effect with a small word array.

Each byte offset is split into three fields using the programmed widths. The column field starts at bit 0, the bank field sits directly above it, and the row field sits above the bank field. Each field is first masked to the widths the selected real chip actually has. It is then reduced to the position of its highest set bit. The three positions select one 32-bit cell in a 16 x 3 x 13 array.

An activity flag tells the surrounding fabric when the programmed geometry differs from the real chip. Routing between this block and ordinary memory is outside the block.

Top module: `alias_probe_mem`

## Requirements
- R1: After reset `busy_o` is high for exactly 624 cycles while the cell array is cleared. Accesses are refused (`gnt_o` low) while `busy_o` is high. Every cell reads zero once `busy_o` has fallen.
- R2: The configured widths are plain unsigned bit counts. The column field is `addr_i[col_w-1:0]`. The bank field is the next `bank_w` bits above it. The row field is the next `row_w` bits above the bank field.
- R3: The row, bank and column cell indices are each the position of the highest set bit of the field, counting only the real chip's bits for that field. A field with no such bit set gives index 0. The cell is row index x 39 + bank index x 13 + column index.
- R4: `chip_sel_i` encodes the real chip as follows: 0 selects 256 MiB with 12 row bits, 1 selects 512 MiB with 13 row bits, 2 selects 1024 MiB with 14 row bits, and 3 is unsupported. Every supported chip has 3 bank bits and 13 column bits.
- R5: `active_o` is high when the chip is supported and at least one stored width differs from the chip's widths. The stored geometry resets to 12/3/13 and changes on the cycle after `cfg_load_i`.
- R6: A granted write stores `wdata_i` in the selected cell. A granted read raises `rvalid_o` on the following cycle, with that cell's contents on `rdata_o`.
- R7: With `chip_sel_i` = 3, reads return zero and writes leave every cell unchanged.
- R8: Only word accesses are granted: `gnt_o` requires `req_i` and `word_i` to be high.
- R9: An access in the same cycle as `cfg_load_i` is decoded with the geometry that was stored before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_load_i | input | 1 | Store the configured widths |
| cfg_row_w_i | input | 5 | Configured row width in bits |
| cfg_bank_w_i | input | 5 | Configured bank width in bits |
| cfg_col_w_i | input | 5 | Configured column width in bits |
| chip_sel_i | input | 2 | Real chip select (0/1/2 = 256/512/1024 MiB, 3 unsupported) |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | Access is a full 32-bit word |
| addr_i | input | 32 | Byte offset |
| wdata_i | input | 32 | Write data |
| gnt_o | output | 1 | Access accepted this cycle |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| busy_o | output | 1 | Clear sweep in progress |
| active_o | output | 1 | Configured geometry differs from chip |

## Verification
A geometry load and an access can fall in the same cycle. The bench provokes this by raising `cfg_load_i`, with a narrower column width, in the same cycle as a read. It chooses an offset that maps to different cells under the old and the new geometry. The read is judged correct only if it returns the marker stored under the old geometry. A second read at the same offset on the next cycle must return the marker of the cell selected by the new geometry.

// File: rtl/alias_probe_pkg.sv
package alias_probe_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned GEOM_W = 5;

  typedef struct packed {
    logic              ok;
    logic [GEOM_W-1:0] row_w;
    logic [GEOM_W-1:0] bank_w;
    logic [GEOM_W-1:0] col_w;
  } geom_t;

  function automatic geom_t chip_geom(input logic [1:0] sel);
    geom_t g;
    g.ok     = 1'b1;
    g.bank_w = GEOM_W'(3);
    g.col_w  = GEOM_W'(13);
    case (sel)
      2'd0:    g.row_w = GEOM_W'(12);
      2'd1:    g.row_w = GEOM_W'(13);
      2'd2:    g.row_w = GEOM_W'(14);
      default: begin
        g.ok     = 1'b0;
        g.row_w  = '0;
        g.bank_w = '0;
        g.col_w  = '0;
      end
    endcase
    return g;
  endfunction

  function automatic logic [ADDR_W-1:0] low_mask(input logic [GEOM_W-1:0] w);
    return (ADDR_W'(1) << w) - ADDR_W'(1);
  endfunction

  function automatic logic [4:0] top_bit(input logic [ADDR_W-1:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < int'(ADDR_W); i++) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/alias_geom_regs.sv
module alias_geom_regs
  import alias_probe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [GEOM_W-1:0] row_w_i,
  input  logic [GEOM_W-1:0] bank_w_i,
  input  logic [GEOM_W-1:0] col_w_i,
  input  geom_t             chip_i,
  output geom_t             cfg_o,
  output logic              active_o
);
  logic [GEOM_W-1:0] row_q, bank_q, col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= GEOM_W'(12);
      bank_q <= GEOM_W'(3);
      col_q  <= GEOM_W'(13);
    end else if (load_i) begin
      row_q  <= row_w_i;
      bank_q <= bank_w_i;
      col_q  <= col_w_i;
    end
  end

  always_comb begin
    cfg_o.ok     = 1'b1;
    cfg_o.row_w  = row_q;
    cfg_o.bank_w = bank_q;
    cfg_o.col_w  = col_q;
  end

  assign active_o = chip_i.ok &&
                    ((row_q != chip_i.row_w) || (bank_q != chip_i.bank_w) ||
                     (col_q != chip_i.col_w));
endmodule

// File: rtl/alias_addr_map.sv
module alias_addr_map
  import alias_probe_pkg::*;
#(
  parameter int unsigned BANKS = 3,
  parameter int unsigned COLS  = 13,
  parameter int unsigned IDX_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  geom_t             cfg_i,
  input  geom_t             chip_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned PLANE = BANKS * COLS;

  logic [GEOM_W:0]   row_sh;
  logic [ADDR_W-1:0] col_f, bank_f, row_f;
  logic [4:0]        ci, bi, ri;

  assign row_sh = {1'b0, cfg_i.col_w} + {1'b0, cfg_i.bank_w};

  always_comb begin
    col_f  = addr_i & low_mask(cfg_i.col_w);
    bank_f = (addr_i >> cfg_i.col_w) & low_mask(cfg_i.bank_w);
    row_f  = (addr_i >> row_sh) & low_mask(cfg_i.row_w);
    // only bits the real chip decodes take part
    ci = top_bit(col_f  & low_mask(chip_i.col_w));
    bi = top_bit(bank_f & low_mask(chip_i.bank_w));
    ri = top_bit(row_f  & low_mask(chip_i.row_w));
    idx_o = IDX_W'(int'(ri) * int'(PLANE) + int'(bi) * int'(COLS) + int'(ci));
  end
endmodule

// File: rtl/alias_cell_ram.sv
module alias_cell_ram #(
  parameter int unsigned DEPTH  = 624,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic [IDX_W-1:0]  clr_q;
  logic              busy_q;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (clr_q == IDX_W'(DEPTH - 1)) busy_q <= 1'b0;
      else                            clr_q  <= clr_q + IDX_W'(1);
    end
  end

  // sweep owns the write port until done
  assign wr_en   = busy_q | we_i;
  assign wr_idx  = busy_q ? clr_q : idx_i;
  assign wr_data = busy_q ? '0 : wdata_i;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (re_i)  rdata_q     <= mem[idx_i];
  end

  assign rdata_o = rdata_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/alias_probe_mem.sv
module alias_probe_mem
  import alias_probe_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROWS   = 16,
  parameter int unsigned BANKS  = 3,
  parameter int unsigned COLS   = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [4:0]        cfg_row_w_i,
  input  logic [4:0]        cfg_bank_w_i,
  input  logic [4:0]        cfg_col_w_i,
  input  logic [1:0]        chip_sel_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [31:0]       addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              gnt_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              active_o
);
  localparam int unsigned DEPTH = ROWS * BANKS * COLS;
  localparam int unsigned IDX_W = $clog2(DEPTH);

  geom_t             chip, cfg;
  logic [IDX_W-1:0]  cell_idx;
  logic              ram_we, ram_re, busy;
  logic [DATA_W-1:0] ram_rdata;
  logic              rvalid_q, zero_q;

  assign chip = chip_geom(chip_sel_i);

  alias_geom_regs u_geom (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cfg_load_i),
    .row_w_i  (cfg_row_w_i),
    .bank_w_i (cfg_bank_w_i),
    .col_w_i  (cfg_col_w_i),
    .chip_i   (chip),
    .cfg_o    (cfg),
    .active_o (active_o)
  );

  alias_addr_map #(.BANKS(BANKS), .COLS(COLS), .IDX_W(IDX_W)) u_map (
    .addr_i (addr_i),
    .cfg_i  (cfg),
    .chip_i (chip),
    .idx_o  (cell_idx)
  );

  assign gnt_o  = req_i & word_i & ~busy;
  assign ram_we = gnt_o & we_i & chip.ok;
  assign ram_re = gnt_o & ~we_i;

  alias_cell_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ram_we),
    .re_i    (ram_re),
    .idx_i   (cell_idx),
    .wdata_i (wdata_i),
    .rdata_o (ram_rdata),
    .busy_o  (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      zero_q   <= 1'b0;
    end else begin
      rvalid_q <= ram_re;
      if (ram_re) zero_q <= ~chip.ok;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = zero_q ? '0 : ram_rdata;
  assign busy_o   = busy;
endmodule

// File: rtl/alias_probe_chk.sv
module alias_probe_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_load_i,
  input logic [1:0]  chip_sel_i,
  input logic        req_i,
  input logic        we_i,
  input logic        word_i,
  input logic        gnt_o,
  input logic        rvalid_o,
  input logic [31:0] rdata_o,
  input logic        busy_o,
  input logic        active_o
);
  AST_BUSY_REFUSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !gnt_o); // R1
  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o && !we_i) |=> rvalid_o); // R6
  AST_NO_STRAY_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(gnt_o && !we_i)); // R6
  AST_WORD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |-> (req_i && word_i)); // R8
  AST_UNSUP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(chip_sel_i == 2'd3)) |-> (rdata_o == 32'h0)); // R7
  AST_ACTIVE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cfg_load_i) && $stable(chip_sel_i)) |-> $stable(active_o)); // R5
  AST_UNSUP_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_sel_i == 2'd3) |-> !active_o); // R4
endmodule

bind alias_probe_mem alias_probe_chk u_chk (.*);

// File: tb/sim_alias_probe_mem.sv
module sim_alias_probe_mem;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_load_i = 1'b0;
  logic [4:0]  cfg_row_w_i = 5'd12, cfg_bank_w_i = 5'd3, cfg_col_w_i = 5'd13;
  logic [1:0]  chip_sel_i = 2'd0;
  logic        req_i = 1'b0, we_i = 1'b0, word_i = 1'b1;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic        gnt_o, rvalid_o, busy_o, active_o;
  logic [31:0] rdata_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  alias_probe_mem u0 (.*);

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
  } vec_t;

  // geometry 14/3/13 on a 256 MiB chip; reads carry expected data
  localparam vec_t VECS [0:13] = '{
    '{1'b1, 32'h0000_0000, 32'hA1A1_0001},
    '{1'b0, 32'h0000_0001, 32'hA1A1_0001},
    '{1'b1, 32'h0000_0004, 32'hB2B2_0002},
    '{1'b0, 32'h0000_0007, 32'hB2B2_0002},
    '{1'b0, 32'h1000_0000, 32'hA1A1_0001},
    '{1'b1, 32'h0000_6000, 32'hC3C3_0003},
    '{1'b0, 32'h0000_4000, 32'hC3C3_0003},
    '{1'b0, 32'h0000_2000, 32'hA1A1_0001},
    '{1'b1, 32'h0003_0000, 32'hD4D4_0004},
    '{1'b0, 32'h0002_0010, 32'h0000_0000},
    '{1'b0, 32'h0002_0001, 32'hD4D4_0004},
    '{1'b0, 32'h0800_0000, 32'h0000_0000},
    '{1'b1, 32'h0000_1FFF, 32'hE5E5_0005},
    '{1'b0, 32'h0000_1000, 32'hE5E5_0005}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                        input logic word, input logic ld,
                        output logic g, output logic rv, output logic [31:0] rd);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = addr; wdata_i = wd; word_i = word; cfg_load_i = ld;
    #1 g = gnt_o;
    @(negedge clk_i);
    req_i = 1'b0; cfg_load_i = 1'b0; word_i = 1'b1;
    rv = rvalid_o; rd = rdata_o;
  endtask

  task automatic rd_chk(input logic [31:0] addr, input logic [31:0] exp, input string req);
    logic g, rv;
    logic [31:0] rd;
    access(1'b0, addr, '0, 1'b1, 1'b0, g, rv, rd);
    check(g && rv && rd == exp, req, rd, exp);
  endtask

  task automatic wr(input logic [31:0] addr, input logic [31:0] wd);
    logic g, rv;
    logic [31:0] rd;
    access(1'b1, addr, wd, 1'b1, 1'b0, g, rv, rd);
    check(g && !rv, "R6 write grant", {31'b0, g}, 32'h1);
  endtask

  task automatic load(input logic [4:0] r, input logic [4:0] b, input logic [4:0] c);
    @(negedge clk_i);
    cfg_row_w_i = r; cfg_bank_w_i = b; cfg_col_w_i = c; cfg_load_i = 1'b1;
    @(negedge clk_i);
    cfg_load_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int busy_cnt;
    logic g, rv;
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: request held through the sweep must never be granted
    req_i = 1'b1; we_i = 1'b0; addr_i = '0;
    busy_cnt = 0;
    g = 1'b0;
    while (busy_o && busy_cnt < 2000) begin
      #1 if (gnt_o) g = 1'b1;
      busy_cnt++;
      @(negedge clk_i);
    end
    req_i = 1'b0;
    check(busy_cnt == 624, "R1 sweep length", busy_cnt, 624);
    check(!g, "R1 refused while busy", {31'b0, g}, 32'h0);
    check(!active_o, "R5 reset geometry inactive", {31'b0, active_o}, 32'h0);
    rd_chk(32'h0000_0000, 32'h0, "R1 cleared cell");
    rd_chk(32'h0000_1FFF, 32'h0, "R1 cleared cell");

    // R5: load a larger row width, active the cycle after
    @(negedge clk_i);
    cfg_row_w_i = 5'd14; cfg_bank_w_i = 5'd3; cfg_col_w_i = 5'd13; cfg_load_i = 1'b1;
    #1 check(!active_o, "R5 active before load edge", {31'b0, active_o}, 32'h0);
    @(negedge clk_i);
    cfg_load_i = 1'b0;
    check(active_o, "R5 active after load", {31'b0, active_o}, 32'h1);

    // R2 R3 R6: table walk
    foreach (VECS[i]) begin
      if (VECS[i].we) wr(VECS[i].addr, VECS[i].data);
      else rd_chk(VECS[i].addr, VECS[i].data, "R2 R3 R6 table read");
    end

    // R8: non-word write refused and has no effect
    access(1'b1, 32'h0, 32'h5555_5555, 1'b0, 1'b0, g, rv, rd);
    check(!g, "R8 non-word refused", {31'b0, g}, 32'h0);
    rd_chk(32'h0000_0000, 32'hA1A1_0001, "R8 cell unchanged");

    // R4: 1024 MiB chip has 14 row bits, geometry matches
    @(negedge clk_i); chip_sel_i = 2'd2;
    #1 check(!active_o, "R4 matching chip inactive", {31'b0, active_o}, 32'h0);
    rd_chk(32'h1000_0000, 32'h0, "R4 row bit 12 is real");
    rd_chk(32'h0000_0000, 32'hA1A1_0001, "R4 base cell");

    // R7: unsupported chip
    @(negedge clk_i); chip_sel_i = 2'd3;
    #1 check(!active_o, "R7 unsupported inactive", {31'b0, active_o}, 32'h0);
    rd_chk(32'h0000_0000, 32'h0, "R7 read zero");
    access(1'b1, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, g, rv, rd);
    @(negedge clk_i); chip_sel_i = 2'd0;
    rd_chk(32'h0000_0000, 32'hA1A1_0001, "R7 write ignored");

    // R9: load col width 12 together with a read at 0x1000
    @(negedge clk_i);
    cfg_row_w_i = 5'd14; cfg_bank_w_i = 5'd3; cfg_col_w_i = 5'd12;
    access(1'b0, 32'h0000_1000, '0, 1'b1, 1'b1, g, rv, rd);
    check(g && rv && rd == 32'hE5E5_0005, "R9 old geometry used", rd, 32'hE5E5_0005);
    check(active_o, "R5 active col differs", {31'b0, active_o}, 32'h1);
    rd_chk(32'h0000_1000, 32'hA1A1_0001, "R9 new geometry next");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule